// File: doc/BRIEF.md
# Shared-Address RAM Cycle Sequencer

This block sits between a CPU bus and a byte-wide static RAM. It serves reads and writes at the same addresses with no direction signal from the CPU. A local clock runs at four times the CPU rate, so each CPU machine cycle splits into four quarters. The block restarts its quarter count on every rising edge of the CPU clock.

In the first quarter of every cycle whose address falls inside the RAM window, the RAM is read and the block drives the byte onto the data bus. In the remaining quarters the block stops driving and only weakly holds the byte it read. A RAM write is open from the start of the second quarter to the end of the third. The value written is whatever the bus carries: the CPU's value if the CPU drives, or otherwise the byte that was just read. A CPU read therefore leaves the RAM unchanged, and a CPU write replaces the byte. The strength contest on the bus is modelled by a single CPU-drives flag.

Top module: `ram_rw_seq`

## Requirements
- R1: After reset, and until the first rising edge of the CPU clock is sampled, ram_oe_o, ram_we_o, bus_oe_o and bus_keep_o stay low.
- R2: A rising edge of cpu_clk_i sampled at a clk edge starts a cycle. If the captured address is inside the window, ram_oe_o and bus_oe_o are high for exactly the next clk period, the first quarter. During that quarter bus_data_o shows ram_rdata_i unless the CPU drives.
- R3: ram_we_o is high only in the second and third quarters of a cycle inside the window. It is never high together with ram_oe_o, and it only rises directly after a read quarter.
- R4: From the second quarter until the next cycle starts, bus_keep_o is high. When the CPU is not driving, bus_data_o equals the byte read in the first quarter.
- R5: When cpu_drive_i is high, bus_data_o and ram_wdata_o equal cpu_data_i. The RAM keeps the value present at the last clk edge of the third quarter, so a CPU that drives only during the third quarter still sets the byte.
- R6: When the CPU does not drive in the third quarter, the byte read in the first quarter is written back. This holds even if the CPU drove during the second quarter, so the stored byte ends unchanged.
- R7: Two back-to-back cycles to one address, with no drive in the first cycle and drive in the second, leave the old byte after the first cycle and the CPU's byte after the second.
- R8: For an address below WIN_LO or above WIN_HI, ram_oe_o, ram_we_o and bus_oe_o stay low for the whole cycle.
- R9: A CPU rising edge that comes early, in any quarter, ends the current cycle. The next clk period is the first quarter of the new cycle.
- R10: ram_addr_o equals the CPU address minus WIN_LO, captured when the cycle starts. It is held for the rest of the cycle, including both window bounds.
- R11: If the CPU clock is slower than four clk periods, the sequencer rests in the fourth quarter and gives exactly two write clocks per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, four times the CPU rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_clk_i | input | 1 | CPU clock level, sampled on clk |
| cpu_addr_i | input | ADDR_W | CPU address |
| cpu_data_i | input | DATA_W | Value the CPU puts on the bus when it drives |
| cpu_drive_i | input | 1 | CPU actively drives the data bus |
| bus_data_o | output | DATA_W | Resolved data bus value |
| bus_oe_o | output | 1 | Block drives the data bus strongly |
| bus_keep_o | output | 1 | Block weakly holds the read byte |
| ram_addr_o | output | RAM_AW | RAM address |
| ram_rdata_i | input | DATA_W | RAM read data |
| ram_wdata_o | output | DATA_W | RAM write data |
| ram_oe_o | output | 1 | RAM output enable |
| ram_we_o | output | 1 | RAM write enable |

## Verification
The RAM read and the write-back happen in the same machine cycle. The question that matters is which source ends up in the RAM when the CPU drives during only part of that cycle. The bench drives the CPU for the whole cycle, only in the third quarter, or only in the second quarter. It also runs a read-modify-write pair to one address and an early CPU edge that cuts a cycle short. A behavioural model keeps its own copy of the memory and its own quarter count. Each clock it predicts the strobes and the bus value, and after each cycle the bench compares the stored byte with the value the requirements give.

// File: rtl/ram_rw_seq_pkg.sv
package ram_rw_seq_pkg;

  typedef enum logic [1:0] {
    Q_READ  = 2'd0,
    Q_WR1   = 2'd1,
    Q_WR2   = 2'd2,
    Q_REST  = 2'd3
  } quarter_t;

  // Address inside the inclusive window [lo, hi]
  function automatic logic in_window(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Offset of a CPU address into the RAM
  function automatic logic [31:0] win_offset(logic [31:0] a, logic [31:0] lo);
    return a - lo;
  endfunction

  // Quarter following the current one: restart on a CPU edge, else advance and rest at the end
  function automatic quarter_t next_quarter(quarter_t q, logic edge_seen);
    if (edge_seen)      return Q_READ;
    else if (q == Q_REST) return Q_REST;
    else                return quarter_t'(q + 2'd1);
  endfunction

  function automatic logic is_write_quarter(quarter_t q);
    return (q == Q_WR1) || (q == Q_WR2);
  endfunction

endpackage

// File: rtl/rws_quarter_timer.sv
module rws_quarter_timer
  import ram_rw_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cpu_clk_i,
  output quarter_t quarter_o,
  output logic     start_o,
  output logic     active_o
);

  logic     cpu_clk_q;
  quarter_t quarter_q;
  logic     active_q;

  assign start_o = cpu_clk_i & ~cpu_clk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_clk_q <= 1'b0;
      quarter_q <= Q_REST;
      active_q  <= 1'b0;
    end else begin
      cpu_clk_q <= cpu_clk_i;
      quarter_q <= next_quarter(quarter_q, start_o);
      if (start_o) active_q <= 1'b1;
    end
  end

  assign quarter_o = quarter_q;
  assign active_o  = active_q;

endmodule

// File: rtl/rws_addr_capture.sv
module rws_addr_capture
  import ram_rw_seq_pkg::*;
#(
  parameter int unsigned           ADDR_W = 13,
  parameter int unsigned           RAM_AW = 8,
  parameter logic [ADDR_W-1:0]     WIN_LO = 13'h0100,
  parameter logic [ADDR_W-1:0]     WIN_HI = 13'h01FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              hit_o
);

  logic [RAM_AW-1:0] off_q;
  logic              hit_q;
  logic [31:0]       off_full;
  logic              hit_now;

  assign off_full = win_offset(32'(cpu_addr_i), 32'(WIN_LO));
  assign hit_now  = in_window(32'(cpu_addr_i), 32'(WIN_LO), 32'(WIN_HI));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q <= '0;
      hit_q <= 1'b0;
    end else if (start_i) begin
      off_q <= RAM_AW'(off_full);
      hit_q <= hit_now;
    end
  end

  assign ram_addr_o = off_q;
  assign hit_o      = hit_q;

endmodule

// File: rtl/rws_bus_keeper.sv
module rws_bus_keeper #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              read_q_i,
  input  logic              hold_q_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic              cpu_drive_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_oe_o,
  output logic              bus_keep_o
);

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] local_val;

  always_ff @(posedge clk) begin
    if (!rst_n)        hold_q <= '0;
    else if (read_q_i) hold_q <= ram_rdata_i;
  end

  // Strong drive in the read quarter, weak hold afterwards; CPU drive wins over both
  assign local_val  = read_q_i ? ram_rdata_i : hold_q;
  assign bus_data_o = cpu_drive_i ? cpu_data_i : local_val;
  assign bus_oe_o   = read_q_i;
  assign bus_keep_o = hold_q_i;

endmodule

// File: rtl/ram_rw_seq.sv
module ram_rw_seq
  import ram_rw_seq_pkg::*;
#(
  parameter int unsigned       ADDR_W = 13,
  parameter int unsigned       DATA_W = 8,
  parameter int unsigned       RAM_AW = 8,
  parameter logic [ADDR_W-1:0] WIN_LO = 13'h0100,
  parameter logic [ADDR_W-1:0] WIN_HI = 13'h01FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_clk_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic              cpu_drive_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_oe_o,
  output logic              bus_keep_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ram_oe_o,
  output logic              ram_we_o
);

  quarter_t quarter;
  logic     active;
  logic     hit;

  // Named internal events for the checker
  logic ev_start;
  logic ev_capture;
  logic ev_commit;
  logic acc_hit;

  rws_quarter_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_clk_i (cpu_clk_i),
    .quarter_o (quarter),
    .start_o   (ev_start),
    .active_o  (active)
  );

  rws_addr_capture #(
    .ADDR_W (ADDR_W),
    .RAM_AW (RAM_AW),
    .WIN_LO (WIN_LO),
    .WIN_HI (WIN_HI)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (ev_start),
    .cpu_addr_i (cpu_addr_i),
    .ram_addr_o (ram_addr_o),
    .hit_o      (hit)
  );

  assign acc_hit    = active & hit;
  assign ev_capture = acc_hit & (quarter == Q_READ);
  assign ram_we_o   = acc_hit & is_write_quarter(quarter);
  assign ev_commit  = acc_hit & (quarter == Q_WR2);
  assign ram_oe_o   = ev_capture;

  rws_bus_keeper #(
    .DATA_W (DATA_W)
  ) u_keep (
    .clk         (clk),
    .rst_n       (rst_n),
    .read_q_i    (ev_capture),
    .hold_q_i    (acc_hit & (quarter != Q_READ)),
    .ram_rdata_i (ram_rdata_i),
    .cpu_drive_i (cpu_drive_i),
    .cpu_data_i  (cpu_data_i),
    .bus_data_o  (bus_data_o),
    .bus_oe_o    (bus_oe_o),
    .bus_keep_o  (bus_keep_o)
  );

  // The RAM stores whatever the resolved bus carries
  assign ram_wdata_o = bus_data_o;

endmodule

// File: rtl/ram_rw_seq_chk.sv
module ram_rw_seq_chk
  import ram_rw_seq_pkg::*;
#(
  parameter int unsigned       ADDR_W = 13,
  parameter int unsigned       DATA_W = 8,
  parameter int unsigned       RAM_AW = 8,
  parameter logic [ADDR_W-1:0] WIN_LO = 13'h0100,
  parameter logic [ADDR_W-1:0] WIN_HI = 13'h01FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [DATA_W-1:0] cpu_data_i,
  input logic              cpu_drive_i,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              bus_keep_o,
  input logic [RAM_AW-1:0] ram_addr_o,
  input logic [DATA_W-1:0] ram_rdata_i,
  input logic [DATA_W-1:0] ram_wdata_o,
  input logic              ram_oe_o,
  input logic              ram_we_o,
  input logic              ev_start,
  input logic              acc_hit
);

  a_r2_read_one_quarter: assert property (@(posedge clk) disable iff (!rst_n)
    ram_oe_o && !ev_start |=> !ram_oe_o);

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_oe_o && ram_we_o));

  a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_o) |-> $past(ram_oe_o));

  a_r4_keeper_holds: assert property (@(posedge clk) disable iff (!rst_n)
    bus_keep_o && $past(ram_oe_o) && !cpu_drive_i |-> bus_data_o == $past(ram_rdata_i));

  a_r5_cpu_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o && cpu_drive_i |-> ram_wdata_o == cpu_data_i);

  a_r6_writeback_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o && $past(ram_we_o) && !cpu_drive_i && !$past(cpu_drive_i)
      |-> ram_wdata_o == $past(ram_wdata_o));

  a_r8_window_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_oe_o || ram_we_o) |-> acc_hit);

  a_r9_realign: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start && in_window(32'(cpu_addr_i), 32'(WIN_LO), 32'(WIN_HI)) |=> ram_oe_o);

  a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> $stable(ram_addr_o));

endmodule

bind ram_rw_seq ram_rw_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .RAM_AW (RAM_AW),
  .WIN_LO (WIN_LO),
  .WIN_HI (WIN_HI)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_data_i  (cpu_data_i),
  .cpu_drive_i (cpu_drive_i),
  .bus_data_o  (bus_data_o),
  .bus_keep_o  (bus_keep_o),
  .ram_addr_o  (ram_addr_o),
  .ram_rdata_i (ram_rdata_i),
  .ram_wdata_o (ram_wdata_o),
  .ram_oe_o    (ram_oe_o),
  .ram_we_o    (ram_we_o),
  .ev_start    (ev_start),
  .acc_hit     (acc_hit)
);

// File: tb/tb_ram_rw_seq.sv
module tb_ram_rw_seq;

  localparam int LO = 'h100;
  localparam int HI = 'h1FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_clk_i = 1'b0;
  logic [12:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic        cpu_drive_i = 1'b0;
  logic [7:0]  bus_data_o;
  logic        bus_oe_o, bus_keep_o;
  logic [7:0]  ram_addr_o;
  logic [7:0]  ram_rdata_i;
  logic [7:0]  ram_wdata_o;
  logic        ram_oe_o, ram_we_o;

  int n_chk = 0;
  int n_bad = 0;
  int oe_n, we_n;

  always #5 clk = ~clk;

  ram_rw_seq dut (
    .clk(clk), .rst_n(rst_n), .cpu_clk_i(cpu_clk_i), .cpu_addr_i(cpu_addr_i),
    .cpu_data_i(cpu_data_i), .cpu_drive_i(cpu_drive_i), .bus_data_o(bus_data_o),
    .bus_oe_o(bus_oe_o), .bus_keep_o(bus_keep_o), .ram_addr_o(ram_addr_o),
    .ram_rdata_i(ram_rdata_i), .ram_wdata_o(ram_wdata_o), .ram_oe_o(ram_oe_o),
    .ram_we_o(ram_we_o)
  );

  // Bench RAM device
  logic [7:0] ram [256];
  assign ram_rdata_i = ram[ram_addr_o];
  always @(posedge clk) if (ram_we_o) ram[ram_addr_o] <= ram_wdata_o;

  function automatic logic [7:0] seed(int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  // Behavioural reference model
  logic [7:0] exp_mem [256];
  int         m_ph;
  bit         m_act, m_hit, m_prev;
  logic [7:0] m_off, m_hold;

  function automatic bit x_oe();   return m_act && m_hit && m_ph == 0; endfunction
  function automatic bit x_we();   return m_act && m_hit && (m_ph == 1 || m_ph == 2); endfunction
  function automatic bit x_keep(); return m_act && m_hit && m_ph != 0; endfunction
  function automatic logic [7:0] x_bus();
    if (cpu_drive_i) return cpu_data_i;
    if (x_oe())      return exp_mem[m_off];
    return m_hold;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 3; m_act = 0; m_hit = 0; m_prev = 0; m_hold = 0; m_off = 0;
    end else begin
      if (x_we()) exp_mem[m_off] = x_bus();
      if (x_oe()) m_hold = exp_mem[m_off];
      if (cpu_clk_i && !m_prev) begin
        m_ph  = 0;
        m_act = 1;
        m_hit = (int'(cpu_addr_i) >= LO) && (int'(cpu_addr_i) <= HI);
        m_off = 8'(int'(cpu_addr_i) - LO);
      end else if (m_ph < 3) begin
        m_ph++;
      end
      m_prev = cpu_clk_i;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R2 ram_oe", int'(ram_oe_o), int'(x_oe()));
    chk("R2 bus_oe", int'(bus_oe_o), int'(x_oe()));
    chk("R3 ram_we", int'(ram_we_o), int'(x_we()));
    chk("R4 bus_keep", int'(bus_keep_o), int'(x_keep()));
    chk("R4 bus_data", int'(bus_data_o), int'(x_bus()));
    if (x_oe() || x_we()) chk("R10 ram_addr", int'(ram_addr_o), int'(m_off));
    if (x_we()) chk("R5 ram_wdata", int'(ram_wdata_o), int'(x_bus()));
    if (ram_oe_o) oe_n++;
    if (ram_we_o) we_n++;
  endtask

  function automatic bit drive_on(int mode, int k);
    case (mode)
      1: return 1'b1;
      2: return k == 3;
      3: return k == 2;
      default: return 1'b0;
    endcase
  endfunction

  // One CPU cycle of len clk periods; mode 0 none, 1 whole, 2 third quarter, 3 second quarter
  task automatic run_cycle(logic [12:0] a, int mode, logic [7:0] d, int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      cmp_all();
      cpu_clk_i   = (k < (len + 1) / 2);
      if (k == 0) cpu_addr_i = a;
      cpu_drive_i = drive_on(mode, k);
      cpu_data_i  = d;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmp_all();
      cpu_clk_i   = 1'b0;
      cpu_drive_i = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i]     = seed(i);
      exp_mem[i] = seed(i);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet until the first CPU edge
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R1 ram_oe", int'(ram_oe_o), 0);
      chk("R1 ram_we", int'(ram_we_o), 0);
      chk("R1 bus_oe", int'(bus_oe_o), 0);
      chk("R1 bus_keep", int'(bus_keep_o), 0);
    end

    run_cycle(13'h0105, 0, 8'h00, 4);
    chk("R6 plain read keeps byte", int'(ram[8'h05]), int'(seed('h05)));
    run_cycle(13'h0105, 1, 8'hA7, 4);
    chk("R5 full drive stored", int'(ram[8'h05]), 'hA7);
    run_cycle(13'h01F0, 2, 8'h3C, 4);
    chk("R5 late drive stored", int'(ram[8'hF0]), 'h3C);
    run_cycle(13'h0110, 3, 8'h99, 4);
    chk("R6 early drive undone", int'(ram[8'h10]), int'(seed('h10)));

    run_cycle(13'h0123, 0, 8'hC3, 4);
    chk("R7 dummy write-back", int'(ram[8'h23]), int'(seed('h23)));
    run_cycle(13'h0123, 1, 8'hC3, 4);
    chk("R7 real write", int'(ram[8'h23]), 'hC3);

    oe_n = 0; we_n = 0;
    run_cycle(13'h00FF, 1, 8'hEE, 4);
    run_cycle(13'h0200, 1, 8'hEE, 4);
    idle(1);
    chk("R8 no read outside", oe_n, 0);
    chk("R8 no write outside", we_n, 0);
    chk("R8 top byte untouched", int'(ram[8'hFF]), int'(seed('hFF)));
    chk("R8 bottom byte untouched", int'(ram[8'h00]), int'(seed('h00)));

    run_cycle(13'h0100, 1, 8'h11, 4);
    chk("R10 low bound", int'(ram[8'h00]), 'h11);
    run_cycle(13'h01FF, 1, 8'h22, 4);
    chk("R10 high bound", int'(ram[8'hFF]), 'h22);

    run_cycle(13'h0140, 0, 8'h00, 2);
    run_cycle(13'h0141, 2, 8'h5E, 4);
    chk("R9 cut cycle unchanged", int'(ram[8'h40]), int'(seed('h40)));
    chk("R9 next cycle stored", int'(ram[8'h41]), 'h5E);

    oe_n = 0; we_n = 0;
    run_cycle(13'h0160, 1, 8'h77, 7);
    chk("R11 slow cycle stored", int'(ram[8'h60]), 'h77);
    chk("R11 two write clocks", we_n, 2);
    chk("R11 one read clock", oe_n, 1);

    idle(3);
    for (int i = 0; i < 256; i++)
      if (ram[i] !== exp_mem[i]) chk("R6 final memory image", int'(ram[i]), int'(exp_mem[i]));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule